// File: doc/BRIEF.md
# Quad Wiper Register Bank Controller

This block keeps the digital state behind four 8-bit potentiometer wipers. For each wiper it holds a volatile code register, and for each wiper a bank of four stored data registers. Here the data registers are flops that stand in for non-volatile cells. A serial front end decodes the bus and hands the block one event at a time: an address byte, an acknowledged data byte, a read request, or a STOP. The block applies each event to its registers and drives the four wiper codes continuously. Wiper code 0x00 means the tap nearest the low terminal and 0xFF the tap nearest the high terminal.

An internal control byte picks the target of later data accesses. Bit 0 is the stored-bank enable: 0 targets the live wipers, 1 targets a data register. Bits 2:1 select which of the four stored rows is used. Any access to a stored row also pulls values into the wipers, so software can recall a preset with a single read or a single control write.

When a write to stored registers ends with STOP and the protect input is high, the staged bytes are committed to the stored row. The block then raises `busy` for a parameterised number of clock cycles. While `busy` is high the block ignores every front-end event, and the front end is expected to refuse acknowledge during that time.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, wiper i equals stored row 0 of wiper i (taken from parameter `DR_INIT`, byte (i*4+r) holding row r of wiper i). `busy` is low and the control byte reads back as 0x00.
- R2: An address byte of 0x00–0x03 selects wiper 0–3 as the pointer, and 0x07 selects the control byte. Any other value (0x04–0x06, or any value with bits 7:3 nonzero) makes the data bytes and reads that follow it have no effect, until the next valid address byte.
- R3: With control bit 0 clear, each data byte is loaded into the wiper at the pointer, visible on the cycle after the byte strobe. The pointer then advances, wrapping from 3 to 0.
- R4: A data byte sent to the control byte stores bits 2:0, and bits 7:3 read back as zero. If bit 0 of the byte is 1, all four wipers load their stored register from the row given by bits 2:1 of the byte.
- R5: With control bit 0 set, a data byte goes into the wiper at the pointer and is staged for that wiper. In the same cycle every other wiper loads its staged byte if it has one, or otherwise its stored register from the selected row.
- R6: A stored-bank page write accepts any number of bytes with the pointer wrapping. A later byte for the same wiper replaces the earlier staged byte, and only the last byte per wiper is committed.
- R7: A STOP with at least one staged byte and `wpN` high writes the staged bytes into the selected row. `busy` is then high for exactly `WRITE_CYCLES` cycles, starting the cycle after STOP.
- R8: A STOP with `wpN` low discards the staged bytes: the stored row is unchanged and `busy` stays low.
- R9: A read returns the byte on `rdData` with `rdValid` one cycle after `rdReq`. With the pointer on a wiper, it returns the live wiper (control bit 0 = 0), or the stored register in the selected row (bit 0 = 1). A stored read also loads that wiper, and any wiper read advances the pointer with wrap. With the control byte as target, a read returns the control byte and leaves the pointer unchanged.
- R10: While `busy` is high, address bytes, data bytes, reads and STOP have no effect on any register or output.
- R11: A STOP with no staged byte starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; recalls stored row 0 into the wipers |
| cmdAddrValid | input | 1 | Strobe: address byte received |
| cmdAddr | input | 8 | Address byte value |
| wrByteValid | input | 1 | Strobe: data byte acknowledged |
| wrByte | input | 8 | Data byte value |
| rdReq | input | 1 | Strobe: front end needs a byte to transmit |
| stopEvt | input | 1 | Strobe: STOP condition seen |
| wpN | input | 1 | Write protect, low blocks stored commits |
| wiperCodes | output | 32 | Wiper codes, wiper i at bits 8i+7:8i |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | rdData valid this cycle |
| busy | output | 1 | Stored write cycle in progress |

## Verification
The hardest case to reach is a burst of front-end events that arrive while a commit is still running, because they would overwrite the very row being committed. To get there, the bench starts a page write that wraps past all four wipers and commits it. It then sends an address, a data byte, a read request and a second STOP inside the busy window, and checks that the wipers, `busy` and the read path are unchanged. Protect-low discard is tested the same way as the row-load side effects: the stored row is recalled later by a stored read, and the bench compares the recalled value with what was written.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
  localparam int NUM_DCP = 4;
  localparam int NUM_ROW = 4;
  localparam int CODE_W  = 8;
  localparam int PTR_W   = $clog2(NUM_DCP);
  localparam int ROW_W   = $clog2(NUM_ROW);

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic               ldWiperPtr; // volatile write to pointed wiper
    logic               stageNv;    // stored-bank write: stage + wiper side effects
    logic               ldRowAll;   // control write with enable: recall whole row
    logic               commit;     // STOP: staged bytes into stored row
    logic               rdLoad;     // capture read data
    logic               rdStatus;   // read targets control byte
    logic               nvSel;      // current stored-bank enable
    logic [ROW_W-1:0]   rowSel;     // row used by this cycle's action
    logic [PTR_W-1:0]   ptr;        // current wiper pointer
    logic [NUM_DCP-1:0] pendMask;   // wipers holding a staged byte
    logic [CODE_W-1:0]  statusVal;  // control byte as read back
  } wbk_strobe_t;
endpackage

// File: rtl/wbk_ctrl.sv
module wbk_ctrl
  import wbk_pkg::*;
#(
  parameter int WRITE_CYCLES = 250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdAddrValid,
  input  logic [7:0]  cmdAddr,
  input  logic        wrByteValid,
  input  logic [2:0]  wrLow,
  input  logic        rdReq,
  input  logic        stopEvt,
  input  logic        wpN,
  output wbk_strobe_t strobe,
  output logic        busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [7:0] CTRL_ADDR = 8'h07;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_DCP - 1);

  logic [PTR_W-1:0]   ptr;
  logic               tgtValid;
  logic               tgtStatus;
  logic [2:0]         ctrlBits;
  logic [NUM_DCP-1:0] pendMask;
  logic [CNT_W-1:0]   busyCnt;

  logic accept, doAddr, doWr, doRd, doStop, addrIsDcp, addrIsCtrl, nv;
  logic [PTR_W-1:0] ptrNext;

  assign accept     = (busyCnt == '0);
  assign addrIsDcp  = (cmdAddr < 8'(NUM_DCP));
  assign addrIsCtrl = (cmdAddr == CTRL_ADDR);
  assign doAddr     = accept && cmdAddrValid;
  assign doWr       = accept && wrByteValid && tgtValid && !cmdAddrValid;
  assign doRd       = accept && rdReq && tgtValid && !cmdAddrValid && !wrByteValid;
  assign doStop     = accept && stopEvt && !cmdAddrValid && !wrByteValid && !rdReq;
  assign nv         = ctrlBits[0];
  assign ptrNext    = (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
  assign busy       = !accept;

  always_comb begin
    strobe            = '0;
    strobe.ldWiperPtr = doWr && !tgtStatus && !nv;
    strobe.stageNv    = doWr && !tgtStatus && nv;
    strobe.ldRowAll   = doWr && tgtStatus && wrLow[0];
    strobe.rowSel     = strobe.ldRowAll ? wrLow[2:1] : ctrlBits[2:1];
    strobe.commit     = doStop && (|pendMask) && wpN;
    strobe.rdLoad     = doRd;
    strobe.rdStatus   = tgtStatus;
    strobe.nvSel      = nv;
    strobe.ptr        = ptr;
    strobe.pendMask   = pendMask;
    strobe.statusVal  = {5'b0, ctrlBits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      tgtValid  <= 1'b0;
      tgtStatus <= 1'b0;
      ctrlBits  <= '0;
      pendMask  <= '0;
      busyCnt   <= '0;
    end else begin
      if (doAddr) begin
        tgtValid  <= addrIsDcp || addrIsCtrl;
        tgtStatus <= addrIsCtrl;
        if (addrIsDcp) ptr <= cmdAddr[PTR_W-1:0];
      end
      if (doWr) begin
        if (tgtStatus) ctrlBits <= wrLow;
        else begin
          ptr <= ptrNext;
          if (nv) pendMask[ptr] <= 1'b1;
        end
      end
      if (doRd && !tgtStatus) ptr <= ptrNext;
      if (doStop) pendMask <= '0;
      if (strobe.commit) busyCnt <= CNT_W'(WRITE_CYCLES);
      else if (!accept)  busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/wbk_datapath.sv
module wbk_datapath
  import wbk_pkg::*;
#(
  parameter logic [NUM_DCP*NUM_ROW*CODE_W-1:0] DR_INIT = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wbk_strobe_t               strobe,
  input  logic [CODE_W-1:0]         wrByte,
  output logic [NUM_DCP*CODE_W-1:0] wiperCodes,
  output logic [CODE_W-1:0]         rdData,
  output logic                      rdValid
);
  logic [NUM_DCP*CODE_W-1:0] drSelFlat;

  for (genvar i = 0; i < NUM_DCP; i++) begin : g_dcp
    logic [CODE_W-1:0] drRow [NUM_ROW];
    logic [CODE_W-1:0] wiperQ;
    logic [CODE_W-1:0] pendData;
    logic              isPtr;

    assign isPtr = (strobe.ptr == PTR_W'(i));
    assign drSelFlat[i*CODE_W +: CODE_W]  = drRow[strobe.rowSel];
    assign wiperCodes[i*CODE_W +: CODE_W] = wiperQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < NUM_ROW; r++)
          drRow[r] <= DR_INIT[(i*NUM_ROW + r)*CODE_W +: CODE_W];
        wiperQ   <= DR_INIT[(i*NUM_ROW)*CODE_W +: CODE_W];
        pendData <= '0;
      end else begin
        if (strobe.commit && strobe.pendMask[i])
          drRow[strobe.rowSel] <= pendData;
        if (strobe.stageNv && isPtr)
          pendData <= wrByte;
        if ((strobe.ldWiperPtr || strobe.stageNv) && isPtr)
          wiperQ <= wrByte;
        else if (strobe.stageNv)
          wiperQ <= strobe.pendMask[i] ? pendData : drRow[strobe.rowSel];
        else if (strobe.ldRowAll)
          wiperQ <= drRow[strobe.rowSel];
        else if (strobe.rdLoad && !strobe.rdStatus && strobe.nvSel && isPtr)
          wiperQ <= drRow[strobe.rowSel];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdLoad;
      if (strobe.rdLoad) begin
        if (strobe.rdStatus)   rdData <= strobe.statusVal;
        else if (strobe.nvSel) rdData <= drSelFlat[strobe.ptr*CODE_W +: CODE_W];
        else                   rdData <= wiperCodes[strobe.ptr*CODE_W +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl
  import wbk_pkg::*;
#(
  parameter int WRITE_CYCLES = 250000,
  parameter logic [NUM_DCP*NUM_ROW*CODE_W-1:0] DR_INIT = '0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdAddrValid,
  input  logic [7:0]                cmdAddr,
  input  logic                      wrByteValid,
  input  logic [CODE_W-1:0]         wrByte,
  input  logic                      rdReq,
  input  logic                      stopEvt,
  input  logic                      wpN,
  output logic [NUM_DCP*CODE_W-1:0] wiperCodes,
  output logic [CODE_W-1:0]         rdData,
  output logic                      rdValid,
  output logic                      busy
);
  wbk_strobe_t strobe;

  wbk_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdAddrValid(cmdAddrValid), .cmdAddr(cmdAddr),
    .wrByteValid(wrByteValid), .wrLow(wrByte[2:0]), .rdReq(rdReq),
    .stopEvt(stopEvt), .wpN(wpN), .strobe(strobe), .busy(busy)
  );

  wbk_datapath #(.DR_INIT(DR_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(wrByte),
    .wiperCodes(wiperCodes), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/wbk_checker.sv
module wbk_checker #(
  parameter int WRITE_CYCLES = 250000
) (
  input logic        clk,
  input logic        rstN,
  input logic        wpN,
  input logic        stopEvt,
  input logic        rdReq,
  input logic        rdValid,
  input logic        busy,
  input logic [31:0] wiperCodes
);
  int unsigned busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < WRITE_CYCLES)); // R7
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvt && wpN)); // R7
  AST_PROTECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopEvt && !wpN && !busy) |=> !busy); // R8
  AST_READ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdReq && !busy)); // R9
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(wiperCodes)); // R10
endmodule

bind wiper_bank_ctrl wbk_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .wpN(wpN), .stopEvt(stopEvt), .rdReq(rdReq),
  .rdValid(rdValid), .busy(busy), .wiperCodes(wiperCodes)
);

// File: tb/sim_wiper_bank_ctrl.sv
module sim_wiper_bank_ctrl;
  localparam int WC = 20;

  // stored row r of wiper i = 0x30 + 16*i + r
  function automatic logic [127:0] mkInit();
    logic [127:0] v = '0;
    for (int i = 0; i < 4; i++)
      for (int r = 0; r < 4; r++)
        v[(i*4 + r)*8 +: 8] = 8'(8'h30 + 16*i + r);
    return v;
  endfunction
  localparam logic [127:0] INIT = mkInit();

  logic clk = 0, rstN = 0;
  logic cmdAddrValid = 0, wrByteValid = 0, rdReq = 0, stopEvt = 0, wpN = 1;
  logic [7:0] cmdAddr = 0, wrByte = 0, rdData;
  logic [31:0] wiperCodes;
  logic rdValid, busy;

  int checks = 0, fails = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  wiper_bank_ctrl #(.WRITE_CYCLES(WC), .DR_INIT(INIT)) u0 (
    .clk(clk), .rstN(rstN), .cmdAddrValid(cmdAddrValid), .cmdAddr(cmdAddr),
    .wrByteValid(wrByteValid), .wrByte(wrByte), .rdReq(rdReq),
    .stopEvt(stopEvt), .wpN(wpN), .wiperCodes(wiperCodes),
    .rdData(rdData), .rdValid(rdValid), .busy(busy)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkW(input logic [7:0] w3, w2, w1, w0, input string tag);
    chk(wiperCodes, {w3, w2, w1, w0}, tag);
  endtask

  task automatic sendAddr(input logic [7:0] a);
    cmdAddr = a; cmdAddrValid = 1; @(negedge clk); cmdAddrValid = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    wrByte = b; wrByteValid = 1; @(negedge clk); wrByteValid = 0;
  endtask

  task automatic doRead(input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    rdReq = 1; @(negedge clk); rdReq = 0;
  endtask

  task automatic doStop(input logic wp);
    wpN = wp; stopEvt = 1; @(negedge clk); stopEvt = 0; wpN = 1;
  endtask

  // monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected read actual=%h expected=none", rdData);
      end else begin
        chk({24'h0, rdData}, {24'h0, expQ.pop_front()}, tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    chkW(8'h60, 8'h50, 8'h40, 8'h30, "R1 recall in reset");
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chkW(8'h60, 8'h50, 8'h40, 8'h30, "R1 recall after reset");
    chk({31'h0, busy}, 0, "R1 busy idle");
    sendAddr(8'h07);
    doRead(8'h00, "R1 control byte reset");
    doRead(8'h00, "R9 control read keeps target");

    // volatile page from wiper 2 with wrap
    sendAddr(8'h02);
    sendByte(8'hAA); sendByte(8'hBB); sendByte(8'hCC);
    chkW(8'hBB, 8'hAA, 8'h40, 8'hCC, "R3 volatile write wrap");
    doRead(8'h40, "R9 volatile read ptr1");
    doRead(8'hAA, "R9 volatile read ptr2");

    // invalid addresses
    sendAddr(8'h05); sendByte(8'h11);
    chkW(8'hBB, 8'hAA, 8'h40, 8'hCC, "R2 addr 05 ignored");
    sendAddr(8'h81); sendByte(8'h22);
    chkW(8'hBB, 8'hAA, 8'h40, 8'hCC, "R2 addr 81 ignored");

    // control byte: reserved bits, then row recall
    sendAddr(8'h07); sendByte(8'hF8);
    doRead(8'h00, "R4 reserved bits zero");
    chkW(8'hBB, 8'hAA, 8'h40, 8'hCC, "R4 no recall when bit0 clear");
    sendByte(8'h05);
    chkW(8'h62, 8'h52, 8'h42, 8'h32, "R4 row 2 recall");
    doRead(8'h05, "R4 control readback");

    // stored page write, protect high
    sendAddr(8'h01);
    sendByte(8'h71);
    chkW(8'h62, 8'h52, 8'h71, 8'h32, "R5 stage first byte");
    sendByte(8'h72);
    chkW(8'h62, 8'h72, 8'h71, 8'h32, "R5 others from staged/row");
    doStop(1);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n, WC, "R7 busy length");
    sendAddr(8'h07); sendByte(8'h05);
    chkW(8'h62, 8'h72, 8'h71, 8'h32, "R7 committed row recall");
    sendAddr(8'h01);
    doRead(8'h71, "R9 stored read ptr1");
    doRead(8'h72, "R9 stored read ptr2");

    // protect low discards
    sendAddr(8'h03); sendByte(8'h9A);
    chkW(8'h9A, 8'h72, 8'h71, 8'h32, "R5 stage on wiper3");
    doStop(0);
    chk({31'h0, busy}, 0, "R8 no busy when protected");
    sendAddr(8'h03);
    doRead(8'h62, "R8 stored row unchanged");
    chkW(8'h62, 8'h72, 8'h71, 8'h32, "R9 stored read loads wiper");

    // five-byte wrap page, then activity during busy
    sendAddr(8'h00);
    sendByte(8'hA1); sendByte(8'hA2); sendByte(8'hA3); sendByte(8'hA4); sendByte(8'hA5);
    chkW(8'hA4, 8'hA3, 8'hA2, 8'hA5, "R6 wrap overwrite wipers");
    doStop(1);
    chk({31'h0, busy}, 1, "R7 busy after STOP");
    sendAddr(8'h01); sendByte(8'h00);
    rdReq = 1; @(negedge clk); rdReq = 0;
    doStop(1);
    @(negedge clk);
    chkW(8'hA4, 8'hA3, 8'hA2, 8'hA5, "R10 events ignored while busy");
    chk({31'h0, busy}, 1, "R10 busy continues");
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    sendAddr(8'h00);
    doRead(8'hA5, "R6 stored wiper0 last byte");
    doRead(8'hA2, "R6 stored wiper1");
    doRead(8'hA3, "R6 stored wiper2");
    doRead(8'hA4, "R6 stored wiper3");

    // STOP with nothing staged
    sendAddr(8'h07); sendByte(8'h04);
    doStop(1);
    chk({31'h0, busy}, 0, "R11 empty STOP no busy");
    sendAddr(8'h07);
    doRead(8'h04, "R4 control bits 2:1 kept");

    repeat (3) @(negedge clk);
    chk(expQ.size(), 0, "R9 all reads returned");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule